// File: doc/BRIEF.md
# Circular Command Queue Consumer

This block drains a ring of fixed-size command entries held in memory. Software (or an upstream agent) writes commands into the ring and moves a producer offset forward; the block holds the consumer offset. Whenever it is enabled and the two offsets differ, it reads the entry under the consumer offset, looks at its opcode, and either retires it on the spot or hands it to an external executor through a request/acknowledge handshake. It then moves the consumer offset forward and wraps it at the end of the ring.

The ring size comes from a page-count field: the field value plus one gives the number of 4 KB pages, and each entry is 32 bytes long. An offset past the end of the ring is reported and blocks all processing. A failed execution or a memory read error freezes the consumer offset on the failing entry and latches a sticky stall that only reset clears. Dropping the enable lets the command in flight finish and stops before the next fetch.

Top module: `cmd_ring_consumer`

## Requirements
- R1: After reset the consumer offset is 0, the stall flag is low, and neither a memory request nor an execute request is raised.
- R2: While the enable input is low, no memory request is issued, even when the producer and consumer offsets differ.
- R3: The ring holds (size field + 1) × 128 entries. The range flag is high exactly when the producer or consumer offset is greater than that count (equal to the count is accepted), and while it is high no command is fetched.
- R4: Each command is fetched with exactly one single-cycle memory request at address base + consumer offset × 32, and a memory request and an execute request are never raised together.
- R5: When the opcode (bits 7:0 of the fetched 64-bit word) is one of 0x03, 0x04, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D or 0x0F, the block raises an execute request that presents that opcode and the full word, and holds both steady until the acknowledge arrives.
- R6: Opcode 0x05 (synchronisation) and every opcode outside the R5 set retire without an execute request.
- R7: After each successful command the consumer offset moves to (offset + 1) modulo the entry count.
- R8: Commands are consumed one after another until the consumer offset equals the producer offset; the block then issues no further requests.
- R9: An acknowledge with the result flag low sets the stall flag and leaves the consumer offset on the failing entry. The stall flag then stays high, and no later request is issued.
- R10: A memory response flagged as an error sets the stall flag and leaves the consumer offset on that entry. No execute request is raised for it.
- R11: Lowering the enable input during a command lets that command complete and advance the offset, then halts before the next fetch. Raising the enable again resumes from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global processing enable |
| queueBase | input | ADDR_W | Byte address of ring entry 0 |
| queueSizeField | input | SIZE_W | Page count minus one |
| writeOffset | input | OFS_W | Producer offset, in entries |
| readOffset | output | OFS_W | Consumer offset, in entries |
| stalled | output | 1 | Sticky failure flag |
| rangeErr | output | 1 | An offset lies beyond the ring |
| memReqValid | output | 1 | Single-cycle read request |
| memReqAddr | output | ADDR_W | Read byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | DATA_W | First 64-bit word of the entry |
| memRspErr | input | 1 | Read failed (qualified by memRspValid) |
| execReq | output | 1 | Execute request, held until acknowledged |
| execOpcode | output | 8 | Opcode of the command being executed |
| execCmdWord | output | DATA_W | Full first word of the command |
| execAck | input | 1 | Executor done |
| execOk | input | 1 | Executor result, sampled with execAck |

## Verification
A corrupted consumer offset shows at once on the memory address of the next fetch, and after the run as a final offset that differs from the producer offset. A bad wrap shows as a skipped or repeated entry in the fetch sequence within one command of the ring boundary. A stall that is not latched, or that is lost, shows as further fetches after the failing entry within about three cycles. A wrong dispatch decision shows as a count of execute requests that does not match the count of handled opcodes in the entries consumed.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int OPCODE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_EXEC,
    ST_STALL
  } cmdqState_e;

  // Strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic captureCmd;
    logic advance;
    logic setStall;
  } cmdqStrobe_t;

  // Conditions reported by the datapath to the sequencer
  typedef struct packed {
    logic pending;
    logic rangeBad;
    logic dispatch;
  } cmdqStatus_t;

  // Opcodes that are forwarded to the external executor (R5); all others retire locally (R6)
  function automatic logic needsHandler(input logic [OPCODE_W-1:0] op);
    case (op)
      8'h03, 8'h04, 8'h08, 8'h09, 8'h0A,
      8'h0B, 8'h0C, 8'h0D, 8'h0F: needsHandler = 1'b1;
      default:                    needsHandler = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cmdq_datapath.sv
module cmdq_datapath
  import cmdq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int SIZE_W      = 8,
  parameter int PAGE_BYTES  = 4096,
  parameter int ENTRY_BYTES = 32,
  localparam int PG_SHIFT    = $clog2(PAGE_BYTES / ENTRY_BYTES),
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES),
  localparam int OFS_W       = SIZE_W + 1 + PG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdqStrobe_t       strobe,
  input  logic [ADDR_W-1:0] queueBase,
  input  logic [SIZE_W-1:0] queueSizeField,
  input  logic [OFS_W-1:0]  writeOffset,
  input  logic [DATA_W-1:0] memRspData,
  output cmdqStatus_t       status,
  output logic [OFS_W-1:0]  readOffset,
  output logic              stalled,
  output logic              rangeErr,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] cmdWord
);

  logic [OFS_W-1:0] rdPtr;
  logic [OFS_W-1:0] rdNext;
  logic [OFS_W-1:0] entryCount;
  logic             stallFlag;
  logic [DATA_W-1:0] cmdReg;

  // R3: ring depth in entries = pages * entries-per-page
  assign entryCount = OFS_W'({1'b0, queueSizeField} + 1'b1) << PG_SHIFT;

  // R7: modulo increment
  always_comb begin
    rdNext = rdPtr + 1'b1;
    if (rdNext == entryCount) rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr     <= '0;
      stallFlag <= 1'b0;
      cmdReg    <= '0;
    end else begin
      if (strobe.advance)    rdPtr     <= rdNext;
      if (strobe.setStall)   stallFlag <= 1'b1;
      if (strobe.captureCmd) cmdReg    <= memRspData;
    end
  end

  // R4: entry address
  assign memReqAddr = queueBase + (ADDR_W'(rdPtr) << ENTRY_SHIFT);

  assign status.pending  = (rdPtr != writeOffset);
  assign status.rangeBad = (writeOffset > entryCount) || (rdPtr > entryCount);
  assign status.dispatch = needsHandler(memRspData[OPCODE_W-1:0]);

  assign readOffset = rdPtr;
  assign stalled    = stallFlag;
  assign rangeErr   = status.rangeBad;
  assign cmdWord    = cmdReg;

endmodule

// File: rtl/cmdq_control.sv
module cmdq_control
  import cmdq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  cmdqStatus_t status,
  input  logic        memRspValid,
  input  logic        memRspErr,
  input  logic        execAck,
  input  logic        execOk,
  output cmdqStrobe_t strobe,
  output logic        memReqValid,
  output logic        execReq
);

  cmdqState_e state;
  cmdqState_e stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        // R2, R3, R8, R11: start a fetch only when allowed and work remains
        if (enable && status.pending && !status.rangeBad) stateNext = ST_FETCH;
      end
      ST_FETCH: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) begin
          if (memRspErr) begin
            strobe.setStall = 1'b1;          // R10
            stateNext       = ST_STALL;
          end else if (status.dispatch) begin
            strobe.captureCmd = 1'b1;        // R5
            stateNext         = ST_EXEC;
          end else begin
            strobe.advance = 1'b1;           // R6
            stateNext      = ST_IDLE;
          end
        end
      end
      ST_EXEC: begin
        if (execAck) begin
          if (execOk) begin
            strobe.advance = 1'b1;           // R7
            stateNext      = ST_IDLE;
          end else begin
            strobe.setStall = 1'b1;          // R9
            stateNext       = ST_STALL;
          end
        end
      end
      ST_STALL: stateNext = ST_STALL;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign memReqValid = (state == ST_FETCH);
  assign execReq     = (state == ST_EXEC);

endmodule

// File: rtl/cmd_ring_consumer.sv
module cmd_ring_consumer
  import cmdq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int SIZE_W      = 8,
  parameter int PAGE_BYTES  = 4096,
  parameter int ENTRY_BYTES = 32,
  localparam int OFS_W      = SIZE_W + 1 + $clog2(PAGE_BYTES / ENTRY_BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [ADDR_W-1:0]   queueBase,
  input  logic [SIZE_W-1:0]   queueSizeField,
  input  logic [OFS_W-1:0]    writeOffset,
  output logic [OFS_W-1:0]    readOffset,
  output logic                stalled,
  output logic                rangeErr,
  output logic                memReqValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  input  logic                memRspValid,
  input  logic [DATA_W-1:0]   memRspData,
  input  logic                memRspErr,
  output logic                execReq,
  output logic [OPCODE_W-1:0] execOpcode,
  output logic [DATA_W-1:0]   execCmdWord,
  input  logic                execAck,
  input  logic                execOk
);

  cmdqStrobe_t strobe;
  cmdqStatus_t status;
  logic [DATA_W-1:0] cmdWord;

  cmdq_control ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .status      (status),
    .memRspValid (memRspValid),
    .memRspErr   (memRspErr),
    .execAck     (execAck),
    .execOk      (execOk),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .execReq     (execReq)
  );

  cmdq_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SIZE_W      (SIZE_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .queueBase      (queueBase),
    .queueSizeField (queueSizeField),
    .writeOffset    (writeOffset),
    .memRspData     (memRspData),
    .status         (status),
    .readOffset     (readOffset),
    .stalled        (stalled),
    .rangeErr       (rangeErr),
    .memReqAddr     (memReqAddr),
    .cmdWord        (cmdWord)
  );

  assign execCmdWord = cmdWord;
  assign execOpcode  = cmdWord[OPCODE_W-1:0];

endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
  parameter int OFS_W  = 16,
  parameter int DATA_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [OFS_W-1:0] writeOffset,
  input logic [OFS_W-1:0] readOffset,
  input logic             stalled,
  input logic             rangeErr,
  input logic             memReqValid,
  input logic             execReq,
  input logic [7:0]       execOpcode,
  input logic [DATA_W-1:0] execCmdWord,
  input logic             execAck
);

  p_fetch_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> $past(enable));

  p_fetch_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> $past(!rangeErr));

  p_single_request_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  p_phase_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(memReqValid && execReq));

  p_exec_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (execReq && !execAck) |=> (execReq && $stable(execOpcode) && $stable(execCmdWord)));

  p_offset_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(readOffset) |-> ((readOffset == $past(readOffset) + 1'b1) || (readOffset == '0)));

  p_stop_at_writer_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> $past(readOffset != writeOffset));

  p_stall_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    stalled |=> (stalled && $stable(readOffset)));

  p_stall_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    stalled |-> (!memReqValid && !execReq));

endmodule

bind cmd_ring_consumer cmdq_checker #(
  .OFS_W  (OFS_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .writeOffset (writeOffset),
  .readOffset  (readOffset),
  .stalled     (stalled),
  .rangeErr    (rangeErr),
  .memReqValid (memReqValid),
  .execReq     (execReq),
  .execOpcode  (execOpcode),
  .execCmdWord (execCmdWord),
  .execAck     (execAck)
);

// File: tb/cmd_ring_consumer_tb_top.sv
`timescale 1ns/1ps
module cmd_ring_consumer_tb_top;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int SIZE_W = 8;
  localparam int OFS_W  = 16;
  localparam logic [ADDR_W-1:0] BASE = 32'h0001_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [ADDR_W-1:0] queueBase = BASE;
  logic [SIZE_W-1:0] queueSizeField = '0;
  logic [OFS_W-1:0]  writeOffset = '0;
  logic [OFS_W-1:0]  readOffset;
  logic stalled, rangeErr, memReqValid, execReq;
  logic [ADDR_W-1:0] memReqAddr;
  logic memRspValid = 1'b0;
  logic [DATA_W-1:0] memRspData = '0;
  logic memRspErr = 1'b0;
  logic [7:0] execOpcode;
  logic [DATA_W-1:0] execCmdWord;
  logic execAck = 1'b0;
  logic execOk = 1'b0;

  int vectors = 0;
  int misses = 0;
  int fetchCount = 0;
  int execCount = 0;
  int errIdx = -1;
  int failIdx = -1;
  int exDelay = 0;
  int exWait = 0;
  int memCnt = 0;
  int pendIdx = 0;
  int tbCount = 128;
  int lastRd = 0;

  always #2 clk = ~clk;

  cmd_ring_consumer dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .queueBase(queueBase),
    .queueSizeField(queueSizeField), .writeOffset(writeOffset),
    .readOffset(readOffset), .stalled(stalled), .rangeErr(rangeErr),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr),
    .execReq(execReq), .execOpcode(execOpcode), .execCmdWord(execCmdWord),
    .execAck(execAck), .execOk(execOk)
  );

  function automatic logic [7:0] opFor(input int i);
    case (i % 12)
      0: opFor = 8'h03;  1: opFor = 8'h05;  2: opFor = 8'h08;  3: opFor = 8'h00;
      4: opFor = 8'h0F;  5: opFor = 8'h04;  6: opFor = 8'h22;  7: opFor = 8'h09;
      8: opFor = 8'h0A;  9: opFor = 8'h0B;  10: opFor = 8'h0C; default: opFor = 8'h0D;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] wordFor(input int i);
    logic [55:0] hi;
    hi = 56'(i * 32'h1357 + 32'hA5);
    wordFor = {hi, opFor(i)};
  endfunction

  function automatic bit handled(input logic [7:0] op);
    handled = (op inside {8'h03, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0F});
  endfunction

  function automatic int handledBetween(input int from, input int upto, input int cnt);
    int n = 0;
    for (int i = from; i != upto; i = (i + 1) % cnt) if (handled(opFor(i))) n++;
    handledBetween = n;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Memory model: responds two cycles after the request
  always @(negedge clk) begin
    memRspValid = 1'b0;
    memRspErr = 1'b0;
    if (memCnt > 0) begin
      memCnt--;
      if (memCnt == 0) begin
        memRspValid = 1'b1;
        memRspData = wordFor(pendIdx);
        memRspErr = (pendIdx == errIdx);
      end
    end
    if (rstN && memReqValid) begin
      chk("R4 fetch address", memReqAddr, BASE + readOffset * 32);
      chk("R4 no overlapping fetch", memCnt, 0);
      pendIdx = readOffset;
      memCnt = 2;
      fetchCount++;
    end
  end

  // Executor model
  always @(negedge clk) begin
    if (execAck) begin
      execAck = 1'b0;
    end else if (rstN && execReq) begin
      if (exWait < exDelay) exWait++;
      else begin
        chk("R5 opcode", execOpcode, opFor(readOffset));
        chk("R5 word", (execCmdWord == wordFor(readOffset)) ? 1 : 0, 1);
        chk("R6 only handled opcodes dispatched", handled(execOpcode) ? 1 : 0, 1);
        execAck = 1'b1;
        execOk = (readOffset != failIdx);
        exWait = 0;
        execCount++;
      end
    end
  end

  // Offset step monitor
  always @(negedge clk) begin
    if (!rstN) lastRd = 0;
    else if (readOffset != lastRd) begin
      chk("R7 offset step", readOffset, (lastRd + 1) % tbCount);
      lastRd = readOffset;
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; writeOffset = '0; queueSizeField = '0;
    errIdx = -1; failIdx = -1; exDelay = 0; tbCount = 128;
    repeat (3) @(negedge clk);
    fetchCount = 0; execCount = 0;
    rstN = 1'b1;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!(readOffset == writeOffset) && !stalled && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int f0;
    int e0;
    // R1 reset state
    doReset();
    @(negedge clk);
    chk("R1 offset", readOffset, 0);
    chk("R1 stalled", stalled, 0);
    chk("R1 memReq", memReqValid, 0);
    chk("R1 execReq", execReq, 0);

    // R2 disabled with work pending
    writeOffset = 5;
    repeat (40) @(negedge clk);
    chk("R2 no fetch while disabled", fetchCount, 0);
    chk("R2 offset held", readOffset, 0);

    // R3 range flag sweep over size field, at count-1, count, count+1
    for (int s = 0; s < 8; s++) begin
      for (int d = -1; d <= 1; d++) begin
        queueSizeField = SIZE_W'(s);
        writeOffset = OFS_W'((s + 1) * 128 + d);
        #1;
        chk("R3 range flag", rangeErr, (d == 1) ? 1 : 0);
      end
    end
    queueSizeField = '0;
    writeOffset = 129;
    enable = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 no fetch when out of range", fetchCount, 0);
    enable = 1'b0;
    writeOffset = 0;

    // R5 R6 R7 R8 main run, then a wrapping run
    doReset();
    writeOffset = 100;
    enable = 1'b1;
    waitDone();
    chk("R8 offset reaches writer", readOffset, 100);
    chk("R8 fetch count", fetchCount, 100);
    chk("R6 dispatch count", execCount, handledBetween(0, 100, 128));
    exDelay = 3;
    e0 = execCount;
    writeOffset = 20;
    waitDone();
    chk("R7 wrapped offset", readOffset, 20);
    chk("R7 wrapped fetch count", fetchCount, 148);
    chk("R6 wrapped dispatch count", execCount - e0, handledBetween(100, 20, 128));
    f0 = fetchCount;
    repeat (30) @(negedge clk);
    chk("R8 idle when caught up", fetchCount, f0);
    chk("R9 no stall on success", stalled, 0);

    // R9 executor failure
    doReset();
    failIdx = 4;
    writeOffset = 10;
    enable = 1'b1;
    waitDone();
    repeat (30) @(negedge clk);
    chk("R9 stalled", stalled, 1);
    chk("R9 offset on failing entry", readOffset, 4);
    chk("R9 no further fetch", fetchCount, 5);

    // R10 memory error
    doReset();
    errIdx = 6;
    writeOffset = 10;
    enable = 1'b1;
    waitDone();
    repeat (30) @(negedge clk);
    chk("R10 stalled", stalled, 1);
    chk("R10 offset on failing entry", readOffset, 6);
    chk("R10 fetch count", fetchCount, 7);
    chk("R10 no exec for failed read", execCount, handledBetween(0, 6, 128));

    // R11 disable mid-run
    doReset();
    exDelay = 2;
    writeOffset = 50;
    enable = 1'b1;
    while (fetchCount < 10) @(negedge clk);
    enable = 1'b0;
    repeat (40) @(negedge clk);
    chk("R11 in-flight command completed", readOffset, 10);
    chk("R11 halted before next fetch", fetchCount, 10);
    enable = 1'b1;
    waitDone();
    chk("R11 resumed to writer", readOffset, 50);
    chk("R11 resumed fetch count", fetchCount, 50);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule